// File: doc/BRIEF.md
# External Trigger Sequencer

This block turns an asynchronous trigger pin into a controlled start of sampling for a data converter. The pin is brought into the clock domain through a two-stage synchronizer. A programmable edge selector then decides which pin transitions count as triggers: rising edges, falling edges, or both. A small state machine accepts the first trigger after software arms the unit. It restarts a parameterized sample-clock divider from phase zero and raises a trigger status bit. From then on the divider issues a one-cycle conversion-start strobe at a fixed period.

With the continuous bit set, every further trigger seen while sampling restarts the divider phase, so the converter always lines up with the most recent trigger. With the continuous bit clear, later triggers are ignored until the unit is armed again. Arming stops sampling and clears the status bit.

The state machine has three states. `ST_IDLE` is the state after reset, and it ignores triggers. `ST_ARMED` waits for a trigger. `ST_RUN` means sampling is active. The named transitions are:
- ARM: `ST_IDLE`→`ST_ARMED`.
- FIRE: `ST_ARMED`→`ST_RUN`, on a trigger.
- RETRIG: `ST_RUN`→`ST_RUN`, on a trigger with continuous mode set; the divider restarts.
- REARM: `ST_RUN`→`ST_ARMED`, on arm.
- HOLD: any state stays where it is when neither arm nor an accepted trigger is present.

Top module: `ext_trig_ctrl`

## Requirements
- R1: After reset all outputs are 0 and the unit is idle. Pin edges before the first arm produce no restart, no strobe and no status.
- R2: With `edge_both`=0 and `edge_fall`=0, only a 0→1 transition of `trig_in` is a trigger.
- R3: With `edge_both`=0 and `edge_fall`=1, only a 1→0 transition of `trig_in` is a trigger.
- R4: With `edge_both`=1, both transitions of `trig_in` are triggers, whatever the value of `edge_fall`.
- R5: With `cont_mode`=0, a trigger while sampling produces no restart and leaves the strobe phase unchanged.
- R6: With `cont_mode`=1, every trigger while sampling pulses `restart_o` and restarts the strobe phase.
- R7: `restart_o` is a one-cycle pulse on the third rising clock edge after the pin changes. `conv_start_o` is high in the cycle after `restart_o`. The worst-case pin-to-first-conversion delay is therefore four cycles, which is 32 ns at 125 MHz and within the 100 ns bound.
- R8: While sampling without a new restart, `conv_start_o` pulses once every `DIV_RATIO` cycles.
- R9: `trig_status_o` rises together with the `restart_o` that starts sampling and stays high while sampling.
- R10: `arm` returns the unit to waiting: `trig_status_o` is 0 from the next cycle, and strobes stop. A trigger decided in the same cycle as `arm` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger pin |
| edge_fall | input | 1 | 0: rising edge triggers, 1: falling edge triggers |
| edge_both | input | 1 | 1: both edges trigger, overriding `edge_fall` |
| cont_mode | input | 1 | 1: retriggering while sampling is allowed |
| arm | input | 1 | Arm / re-arm pulse |
| restart_o | output | 1 | One-cycle sample-clock restart pulse |
| conv_start_o | output | 1 | One-cycle conversion-start strobe |
| trig_status_o | output | 1 | Trigger status (sampling active) |

## Verification
The bench sweeps all eight combinations of the edge and continuous bits. For each one it compares every output, every cycle, against an arithmetic model of the pin pipeline and the divider phase.

The corner cases it targets are:
- Edges before the first arm. A design without an idle state would start sampling.
- The edge the configuration should reject. A wrong polarity decode would restart on it.
- A retrigger in single-shot mode. A design that accepts it would shift the strobe phase.
- An arm landing in the same cycle as a trigger decision. A design with the wrong priority would leave the status set.

Any extra or missing synchronizer stage moves every `restart_o` by a cycle and is caught at once.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } trig_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/trig_edge_sel.sv
module trig_edge_sel
    import ext_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic pol_fall,
    input  logic both_en,
    output logic hit
);
    logic       level_q;
    edge_pair_t edges;

    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    always_comb begin
        edges.rise = level & ~level_q;
        edges.fall = ~level & level_q;
        if (both_en)
            hit = edges.rise | edges.fall;
        else if (pol_fall)
            hit = edges.fall;
        else
            hit = edges.rise;
    end
endmodule

// File: rtl/sclk_div.sv
module sclk_div #(
    parameter int DIV_RATIO = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic strobe
);
    localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            strobe <= 1'b0;
        end else if (restart) begin
            phase  <= '0;
            strobe <= 1'b1;
        end else if (run) begin
            if (phase == LAST) begin
                phase  <= '0;
                strobe <= 1'b1;
            end else begin
                phase  <= phase + 1'b1;
                strobe <= 1'b0;
            end
        end else begin
            strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/ext_trig_ctrl.sv
module ext_trig_ctrl
    import ext_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_RATIO   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic edge_fall,
    input  logic edge_both,
    input  logic cont_mode,
    input  logic arm,
    output logic restart_o,
    output logic conv_start_o,
    output logic trig_status_o
);
    trig_state_e state, state_nxt;
    logic        trig_lvl;
    logic        trig_hit;
    logic        accept;
    logic        running;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (trig_in),
        .q     (trig_lvl)
    );

    trig_edge_sel u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (trig_lvl),
        .pol_fall (edge_fall),
        .both_en  (edge_both),
        .hit      (trig_hit)
    );

    // Transitions: ARM, FIRE, RETRIG, REARM, HOLD
    always_comb begin
        state_nxt = state;
        accept    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (arm) state_nxt = ST_ARMED;                 // ARM
            end
            ST_ARMED: begin
                if (arm) begin
                    state_nxt = ST_ARMED;
                end else if (trig_hit) begin
                    state_nxt = ST_RUN;                        // FIRE
                    accept    = 1'b1;
                end
            end
            ST_RUN: begin
                if (arm) begin
                    state_nxt = ST_ARMED;                      // REARM
                end else if (trig_hit && cont_mode) begin
                    accept    = 1'b1;                          // RETRIG
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_o     <= 1'b0;
            trig_status_o <= 1'b0;
        end else begin
            restart_o     <= accept;
            trig_status_o <= (state_nxt == ST_RUN);
        end
    end

    assign running = (state == ST_RUN);

    sclk_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart_o),
        .run     (running),
        .strobe  (conv_start_o)
    );
endmodule

// File: rtl/ext_trig_ctrl_chk.sv
module ext_trig_ctrl_chk #(
    parameter int DIV_RATIO = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cont_mode,
    input logic arm,
    input logic restart_o,
    input logic conv_start_o,
    input logic trig_status_o
);
    logic [15:0] gap;
    logic        gap_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= '0;
            gap_valid <= 1'b0;
        end else if (conv_start_o) begin
            gap       <= 16'd1;
            gap_valid <= 1'b1;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 16'd1;
        end
    end

    assert_first_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |=> conv_start_o);

    assert_single_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o && $past(trig_status_o)) |-> $past(cont_mode));

    assert_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && !$past(restart_o) && gap_valid) |-> (gap == 16'(DIV_RATIO)));

    assert_status_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_status_o) |-> restart_o);

    assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !trig_status_o);
endmodule

bind ext_trig_ctrl ext_trig_ctrl_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cont_mode     (cont_mode),
    .arm           (arm),
    .restart_o     (restart_o),
    .conv_start_o  (conv_start_o),
    .trig_status_o (trig_status_o)
);

// File: tb/ext_trig_ctrl_tb.sv
module ext_trig_ctrl_tb;
    localparam int DIV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic edge_fall = 1'b0;
    logic edge_both = 1'b0;
    logic cont_mode = 1'b0;
    logic arm = 1'b0;
    logic restart_o, conv_start_o, trig_status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // model state
    int m_state = 0;
    int m_restart = 0;
    int m_strobe = 0;
    int m_cnt = 0;
    int p1 = 0, p2 = 0, p3 = 0;

    always #4 clk = ~clk;

    ext_trig_ctrl #(.SYNC_STAGES(2), .DIV_RATIO(DIV)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_in       (trig_in),
        .edge_fall     (edge_fall),
        .edge_both     (edge_both),
        .cont_mode     (cont_mode),
        .arm           (arm),
        .restart_o     (restart_o),
        .conv_start_o  (conv_start_o),
        .trig_status_o (trig_status_o)
    );

    task automatic compare(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        int r, f, hit, ns, acc, s_new, c_new;
        string sreq;
        @(posedge clk);
        r = (p2 == 1 && p3 == 0) ? 1 : 0;
        f = (p2 == 0 && p3 == 1) ? 1 : 0;
        if (edge_both) hit = r | f;
        else if (edge_fall) hit = f;
        else hit = r;
        sreq = (m_restart != 0) ? "R7" : "R8";
        if (m_restart != 0) begin
            s_new = 1; c_new = 0;
        end else if (m_state == 2) begin
            s_new = (m_cnt == DIV - 1) ? 1 : 0;
            c_new = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
        end else begin
            s_new = 0; c_new = m_cnt;
        end
        ns = m_state; acc = 0;
        if (arm) ns = 1;
        else if (m_state == 1 && hit != 0) begin ns = 2; acc = 1; end
        else if (m_state == 2 && hit != 0 && cont_mode) acc = 1;
        m_state = ns; m_restart = acc; m_strobe = s_new; m_cnt = c_new;
        p3 = p2; p2 = p1; p1 = int'(trig_in);
        @(negedge clk);
        compare(cur_req, "restart_o", int'(restart_o), m_restart);
        compare(sreq, "conv_start_o", int'(conv_start_o), m_strobe);
        compare("R9", "trig_status_o", int'(trig_status_o), (m_state == 2) ? 1 : 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_arm();
        arm = 1'b1; tick(); arm = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; arm = 1'b0; trig_in = 1'b0;
        repeat (3) @(negedge clk);
        compare("R1", "restart_o in reset", int'(restart_o), 0);
        compare("R1", "conv_start_o in reset", int'(conv_start_o), 0);
        compare("R1", "trig_status_o in reset", int'(trig_status_o), 0);
        m_state = 0; m_restart = 0; m_strobe = 0; m_cnt = 0;
        p1 = 0; p2 = 0; p3 = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            edge_fall = c[0];
            edge_both = c[1];
            cont_mode = c[2];
            do_reset();
            cur_req = "R1";
            trig_in = 1'b1; idle(4);
            trig_in = 1'b0; idle(4);
            cur_req = "R10";
            pulse_arm(); idle(3);
            cur_req = edge_both ? "R4" : (edge_fall ? "R3" : "R2");
            trig_in = 1'b1; idle(12);
            trig_in = 1'b0; idle(12);
            cur_req = cont_mode ? "R6" : "R5";
            trig_in = 1'b1; idle(7);
            trig_in = 1'b0; idle(9);
            cur_req = "R10";
            pulse_arm(); idle(4);
            trig_in = 1'b1; tick(); tick();
            arm = 1'b1; tick(); arm = 1'b0;
            idle(6);
            trig_in = 1'b0; idle(10);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule